// File: doc/BRIEF.md
# Four-Output Pulse Width Modulator with Separate Period and Width Time Bases

The block generates four pulse-width-modulated outputs that share one period. A period counter advances on strobes taken from one line of a 16-line strobe bus. A width counter advances on strobes from another line of the same bus, which may be the same line or a different one. Each output rises at the start of every period and falls once the width counter reaches that output's own programmed width. The period and pulse widths can therefore be timed at different resolutions.

Software programs the block through a small word-addressed register port. The port holds a fixed identification value, an enable bit, the two strobe-line selects, the period and the four widths. New period and width values are held in shadow registers and take effect only at the next period boundary, so a running waveform never shows a torn cycle. The strobes are single-cycle enables in the system clock domain.

Top module: `pwm4_dualclk`

## Requirements
- R1: Reading word address 0 returns 0x0003. A write to address 0 changes nothing.
- R2: Bit 0 of the control word at address 1 enables the block. While it is 0, all four outputs are low, both counters are held at zero and the shadows follow the programmed values. Setting it to 1 again starts a new period from its beginning.
- R3: Bits 7:4 of the select word at address 2 pick which strobe-bus line advances the period counter.
- R4: Bits 3:0 of the select word at address 2 pick which strobe-bus line advances the width counter. The width counter holds its value in any cycle without that strobe, and saturates at 0xFFFF.
- R5: A period spans P+1 period strobes, where P is the value at address 3. The period boundary is the strobe seen while the period counter equals P.
- R6: Output i (A to D at addresses 4 to 7) is high from the start of a period while the width count since that start is below its width W. It is low once the count reaches W. W = 0 keeps the output low.
- R7: A nonzero width W greater than or equal to the active period P keeps its output high for the whole period.
- R8: Period and width values written while the block is enabled take effect only at the next period boundary.
- R9: Addresses 1 to 7 read back the last value written: the enable in bit 0 of address 1, and both selects in bits 7:0 of address 2. Unused bits read as 0.
- R10: After reset every register reads 0 (except the identification word) and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_bus | input | 16 | Single-cycle time-base strobes |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr, combinational |
| pwm_out | output | 4 | Pulse outputs, bit 0 is A to bit 3 is D |

## Verification
The assertions check the following on every cycle:
- the outputs are silent while disabled;
- the period counter never passes the active period;
- an output only rises at a period start or on enable;
- the period shadow holds between boundaries;
- the width counter holds without its strobe;
- the identification read returns its fixed value.

Other behaviours can only be shown by the bench's scenarios running against its reference model:
- the exact lengths of periods and pulses under different strobe-line choices;
- the full-high case;
- the deferral of mid-cycle writes;
- the restart after re-enable.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
    localparam logic [15:0] ID_VALUE = 16'h0003;
    localparam int A_ID     = 0;
    localparam int A_CTRL   = 1;
    localparam int A_SEL    = 2;
    localparam int A_PERIOD = 3;
    localparam int A_WIDTH0 = 4;
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs #(
    parameter int CNT_W  = 16,
    parameter int N_OUT  = 4,
    parameter int SEL_W  = 4,
    parameter int ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [15:0]                  wdata,
    output logic [15:0]                  rdata,
    output logic                         en,
    output logic [SEL_W-1:0]             psel,
    output logic [SEL_W-1:0]             wsel,
    output logic [CNT_W-1:0]             prd,
    output logic [N_OUT-1:0][CNT_W-1:0]  wid
);
    import pwm4_pkg::*;

    typedef struct packed {
        logic                        en;
        logic [2*SEL_W-1:0]          sel;
        logic [CNT_W-1:0]            prd;
        logic [N_OUT-1:0][CNT_W-1:0] wid;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            if (int'(addr) == A_CTRL)   r_d.en  = wdata[0];
            if (int'(addr) == A_SEL)    r_d.sel = wdata[2*SEL_W-1:0];
            if (int'(addr) == A_PERIOD) r_d.prd = wdata[CNT_W-1:0];
            for (int i = 0; i < N_OUT; i++)
                if (int'(addr) == A_WIDTH0 + i) r_d.wid[i] = wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (int'(addr) == A_ID)     rdata = ID_VALUE;
        if (int'(addr) == A_CTRL)   rdata[0] = r_q.en;
        if (int'(addr) == A_SEL)    rdata[2*SEL_W-1:0] = r_q.sel;
        if (int'(addr) == A_PERIOD) rdata[CNT_W-1:0] = r_q.prd;
        for (int i = 0; i < N_OUT; i++)
            if (int'(addr) == A_WIDTH0 + i) rdata[CNT_W-1:0] = r_q.wid[i];
    end

    assign en   = r_q.en;
    assign psel = r_q.sel[2*SEL_W-1:SEL_W];
    assign wsel = r_q.sel[SEL_W-1:0];
    assign prd  = r_q.prd;
    assign wid  = r_q.wid;
endmodule

// File: rtl/pwm4_timebase.sv
module pwm4_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             p_tick,
    input  logic             w_tick,
    input  logic [CNT_W-1:0] prd_prog,
    output logic             load,
    output logic [CNT_W-1:0] pcnt,
    output logic [CNT_W-1:0] wcnt,
    output logic [CNT_W-1:0] psh
);
    typedef struct packed {
        logic [CNT_W-1:0] pcnt;
        logic [CNT_W-1:0] wcnt;
        logic [CNT_W-1:0] psh;
    } tb_t;

    tb_t s_d, s_q;
    logic bnd;

    always_comb begin
        s_d  = s_q;
        bnd  = en && p_tick && (s_q.pcnt == s_q.psh);
        load = !en || bnd;
        if (load) begin
            s_d.pcnt = '0;
            s_d.wcnt = '0;
            s_d.psh  = prd_prog;
        end else begin
            if (p_tick) s_d.pcnt = s_q.pcnt + 1'b1;
            if (w_tick && (s_q.wcnt != '1)) s_d.wcnt = s_q.wcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pcnt = s_q.pcnt;
    assign wcnt = s_q.wcnt;
    assign psh  = s_q.psh;
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic [CNT_W-1:0] wid_prog,
    input  logic [CNT_W-1:0] psh,
    input  logic [CNT_W-1:0] wcnt,
    output logic             out
);
    logic [CNT_W-1:0] wsh_d, wsh_q;

    always_comb begin
        wsh_d = load ? wid_prog : wsh_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wsh_q <= '0;
        else        wsh_q <= wsh_d;
    end

    assign out = en && (wsh_q != '0) && ((wsh_q >= psh) || (wcnt < wsh_q));
endmodule

// File: rtl/pwm4_dualclk.sv
module pwm4_dualclk #(
    parameter int CNT_W = 16,
    parameter int N_OUT = 4,
    parameter int BUS_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [BUS_W-1:0]                    strobe_bus,
    input  logic                                reg_we,
    input  logic [$clog2(pwm4_pkg::A_WIDTH0+N_OUT)-1:0] reg_addr,
    input  logic [15:0]                         reg_wdata,
    output logic [15:0]                         reg_rdata,
    output logic [N_OUT-1:0]                    pwm_out
);
    localparam int SEL_W  = $clog2(BUS_W);
    localparam int ADDR_W = $clog2(pwm4_pkg::A_WIDTH0 + N_OUT);

    logic                        en_w, load_w, p_tick_w, w_tick_w;
    logic [SEL_W-1:0]            psel_w, wsel_w;
    logic [CNT_W-1:0]            prd_w, pcnt_w, wcnt_w, psh_w;
    logic [N_OUT-1:0][CNT_W-1:0] wid_w;

    pwm4_regs #(.CNT_W(CNT_W), .N_OUT(N_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .en(en_w), .psel(psel_w), .wsel(wsel_w),
        .prd(prd_w), .wid(wid_w)
    );

    assign p_tick_w = strobe_bus[psel_w];
    assign w_tick_w = strobe_bus[wsel_w];

    pwm4_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .en(en_w), .p_tick(p_tick_w), .w_tick(w_tick_w),
        .prd_prog(prd_w), .load(load_w), .pcnt(pcnt_w), .wcnt(wcnt_w), .psh(psh_w)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_chan
        pwm4_chan #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .en(en_w), .load(load_w),
            .wid_prog(wid_w[i]), .psh(psh_w), .wcnt(wcnt_w), .out(pwm_out[i])
        );
    end
endmodule

// File: rtl/pwm4_dualclk_chk.sv
module pwm4_dualclk_chk #(
    parameter int CNT_W  = 16,
    parameter int N_OUT  = 4,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              load,
    input logic              w_tick,
    input logic [CNT_W-1:0]  pcnt,
    input logic [CNT_W-1:0]  psh,
    input logic [CNT_W-1:0]  wcnt,
    input logic [N_OUT-1:0]  pwm_out,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [15:0]       reg_rdata
);
    assert_id_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == '0) |-> (reg_rdata == 16'h0003));

    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (pwm_out == '0));

    assert_wcnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !$past(load) && !$past(w_tick)) |-> $stable(wcnt));

    assert_pcnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (pcnt <= psh));

    assert_rise_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_out & ~$past(pwm_out)) != '0) |-> $past(load));

    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> $stable(psh));
endmodule

bind pwm4_dualclk pwm4_dualclk_chk #(.CNT_W(CNT_W), .N_OUT(N_OUT), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_w), .load(load_w), .w_tick(w_tick_w),
    .pcnt(pcnt_w), .psh(psh_w), .wcnt(wcnt_w), .pwm_out(pwm_out),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/pwm4_dualclk_tb.sv
module pwm4_dualclk_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] strobe_bus = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  pwm_out;

    pwm4_dualclk u_dut (
        .clk(clk), .rst_n(rst_n), .strobe_bus(strobe_bus), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    int n_vec = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    string cur_req = "R10";

    // reference model state
    int m_en = 0, m_sel = 0, m_prd = 0, m_pc = 0, m_wc = 0, m_psh = 0;
    int m_wid [4] = '{0, 0, 0, 0};
    int m_wsh [4] = '{0, 0, 0, 0};

    always @(negedge clk) begin
        cyc++;
        for (int k = 0; k < 16; k++) strobe_bus[k] <= ((cyc % (k + 1)) == 0);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_sel = 0; m_prd = 0; m_pc = 0; m_wc = 0; m_psh = 0;
            for (int i = 0; i < 4; i++) begin m_wid[i] = 0; m_wsh[i] = 0; end
        end else begin
            bit ptk, wtk;
            ptk = strobe_bus[(m_sel >> 4) & 15];
            wtk = strobe_bus[m_sel & 15];
            if (m_en == 0 || (ptk && m_pc == m_psh)) begin
                m_pc = 0; m_wc = 0; m_psh = m_prd;
                for (int i = 0; i < 4; i++) m_wsh[i] = m_wid[i];
            end else begin
                if (ptk) m_pc++;
                if (wtk && m_wc < 65535) m_wc++;
            end
            if (reg_we) begin
                case (reg_addr)
                    3'd1: m_en  = reg_wdata[0];
                    3'd2: m_sel = int'(reg_wdata[7:0]);
                    3'd3: m_prd = int'(reg_wdata);
                    3'd4, 3'd5, 3'd6, 3'd7: m_wid[reg_addr - 4] = int'(reg_wdata);
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [3:0] exp_out();
        logic [3:0] o;
        for (int i = 0; i < 4; i++)
            o[i] = (m_en != 0) && (m_wsh[i] != 0) && ((m_wsh[i] >= m_psh) || (m_wc < m_wsh[i]));
        return o;
    endfunction

    function automatic logic [15:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return 16'h0003;
            3'd1: return 16'(m_en);
            3'd2: return 16'(m_sel);
            3'd3: return 16'(m_prd);
            default: return 16'(m_wid[a - 4]);
        endcase
    endfunction

    always begin
        @(posedge clk);
        #3;
        if (!done) begin
            n_vec++;
            if (pwm_out !== exp_out()) begin
                n_bad++;
                $display("FAIL %s cycle %0d pwm_out actual %b expected %b", cur_req, cyc, pwm_out, exp_out());
            end
            n_vec++;
            if (reg_rdata !== exp_rd(reg_addr)) begin
                n_bad++;
                $display("FAIL %s cycle %0d rdata@%0d actual %h expected %h", cur_req, cyc, reg_addr, reg_rdata, exp_rd(reg_addr));
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_all();
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            reg_addr = 3'(a);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired, actual running expected finished");
            finish_run();
        end
    end

    initial begin
        // R10: reset state
        cur_req = "R10";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_all();
        // R1: fixed id, write ignored
        cur_req = "R1";
        wr(3'd0, 16'hFFFF);
        @(negedge clk); reg_addr = 3'd0;
        idle(2);
        // R9: readback of every field
        cur_req = "R9";
        wr(3'd1, 16'hFFFE);
        wr(3'd2, 16'hA5C3);
        wr(3'd3, 16'h1234);
        wr(3'd4, 16'h0001); wr(3'd5, 16'hBEEF);
        wr(3'd6, 16'h00FF); wr(3'd7, 16'hFFFF);
        rd_all();
        // R5, R6: both time bases on line 0
        cur_req = "R5_R6";
        wr(3'd2, 16'h0000);
        wr(3'd3, 16'd9);
        wr(3'd4, 16'd0); wr(3'd5, 16'd2); wr(3'd6, 16'd5); wr(3'd7, 16'd8);
        wr(3'd1, 16'h0001);
        idle(45);
        // R7 and R8: widths at and past the period, written while running
        cur_req = "R7_R8";
        wr(3'd4, 16'd9); wr(3'd5, 16'd12); wr(3'd6, 16'hFFFF); wr(3'd7, 16'd1);
        idle(40);
        // R3: slow period line, fast width line
        cur_req = "R3";
        wr(3'd4, 16'd3); wr(3'd5, 16'd7); wr(3'd6, 16'd15); wr(3'd7, 16'd20);
        wr(3'd2, 16'h0031);
        idle(120);
        // R4: fast period line, slow width line
        cur_req = "R4";
        wr(3'd2, 16'h0013);
        idle(120);
        wr(3'd2, 16'h002F);
        idle(150);
        // R8: period shrinks mid-cycle
        cur_req = "R8";
        wr(3'd2, 16'h0000);
        idle(3);
        wr(3'd3, 16'd4);
        wr(3'd4, 16'd2);
        idle(30);
        // R2: disable, then restart
        cur_req = "R2";
        wr(3'd1, 16'h0000);
        idle(10);
        wr(3'd3, 16'd6);
        wr(3'd1, 16'h0001);
        idle(40);
        rd_all();
        finish_run();
    end
endmodule